// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status flags

This block computes one 8-bit operation per cycle between an accumulator value and a second operand: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The result and a new flag byte appear combinationally in the same cycle. The flag byte holds sign, zero, half carry (out of the low nibble), even parity and carry. Spare bit positions in that byte hold fixed constants, so the byte can sit next to the accumulator as the low half of a program status word.

A flag register inside the block captures the new flag byte on a rising clock edge when the write enable is high. The surrounding datapath feeds the stored carry back as the carry input of chained add-with-carry and subtract-with-borrow steps. A separate strobe tells the datapath whether the result should be written to the accumulator. Compare drops that strobe, so only the flags change.

Top module: `alu8_core`

## Requirements
- R1: `op_i` encodes 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare. Add gives `(acc_i + opnd_i) mod 256` and add-with-carry also adds `carry_i`.
- R2: Subtract, subtract-with-borrow and compare give `(acc_i - opnd_i - b) mod 256`, where b is `carry_i` for subtract-with-borrow and 0 otherwise. CY (bit 0) is 1 exactly when the true difference is negative.
- R3: AND, XOR and OR give the bitwise function of `acc_i` and `opnd_i` on `result_o`.
- R4: `acc_we_o` is 0 for compare and 1 for every other code. For compare, `result_o` still shows the difference.
- R5: S (bit 7) equals result bit 7. Z (bit 6) is 1 exactly when the result is 0x00.
- R6: P (bit 2) is 1 exactly when the result has an even number of 1 bits, including zero.
- R7: AC (bit 4) is the carry out of bit 3 for add and add-with-carry. For subtracts and compare it is 1 when the low nibble of `acc_i` is at least the low nibble of `opnd_i` plus b. It is 1 for AND and 0 for XOR and OR.
- R8: CY is the carry out of bit 7 for add and add-with-carry, and 0 for AND, XOR and OR.
- R9: Bit 1 of the flag byte is always 1, and bits 3 and 5 are always 0.
- R10: `carry_i` has no effect on add, subtract or compare.
- R11: `flags_o` resets to 0x02. On a rising edge of `clk_i` with `flag_we_i` high it takes the value `flags_nxt_o` had before the edge. With `flag_we_i` low it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry or borrow |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Result write strobe for the accumulator |
| flags_nxt_o | output | 8 | Flag byte produced by this operation |
| flags_o | output | 8 | Stored flag byte |

## Verification
Two things can happen in the same cycle: a flag register update, and an add-with-carry whose `carry_i` is taken from the stored CY that is being replaced at that edge. The bench sets CY with an overflowing add, then loops `flags_o[0]` into `carry_i` for an add-with-carry of 0x00 and 0x00 with the write enable high. It checks that the result before the edge uses the old carry (0x01) and that the flags after the edge describe that result (0x02). The combinational outputs are then compared with an independent model over every operand pair for each code.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // flag byte bit positions
  localparam int unsigned FB_S   = 7;
  localparam int unsigned FB_Z   = 6;
  localparam int unsigned FB_AC  = 4;
  localparam int unsigned FB_P   = 2;
  localparam int unsigned FB_ONE = 1;
  localparam int unsigned FB_CY  = 0;
  localparam logic [DW-1:0] FLAGS_RST = 8'h02;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8,
  parameter int unsigned H = W / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry for add, borrow for sub
  output logic [W-1:0] sum_o,
  output logic         cy_o,    // carry for add, borrow for sub
  output logic         hc_o
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [H:0]   lo_sum;
  logic [W-H:0] hi_sum;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    c_eff  = sub_i ? ~cin_i : cin_i;
    lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
    hi_sum = {1'b0, a_i[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{(W-H){1'b0}}, lo_sum[H]};
    sum_o  = {hi_sum[W-H-1:0], lo_sum[H-1:0]};
    cy_o   = sub_i ? ~hi_sum[W-H] : hi_sum[W-H];
    hc_o   = lo_sum[H];
  end

  // R2: borrow tracks an unsigned compare of a against b plus borrow-in
  p_borrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> (cy_o == ({1'b0, a_i} < ({1'b0, b_i} + {{W{1'b0}}, cin_i}))));
  // R8: carry tracks an overflow of the widened sum
  p_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> (cy_o == (({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}) > {1'b0, {W{1'b1}}})));
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,  // 0 AND, 1 XOR, 2 OR
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] res_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] nxt_o,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] flags_q;

  always_comb begin
    nxt_o         = '0;
    nxt_o[FB_S]   = res_i[DW-1];
    nxt_o[FB_Z]   = (res_i == '0);
    nxt_o[FB_AC]  = ac_i;
    nxt_o[FB_P]   = ~^res_i;
    nxt_o[FB_ONE] = 1'b1;
    nxt_o[FB_CY]  = cy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= FLAGS_RST;
    else if (we_i) flags_q <= nxt_o;
  end

  assign q_o = flags_q;

  p_flag_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(nxt_o)));
  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  p_fixed_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[FB_ONE] && !q_o[3] && !q_o[5]);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  input  logic          flag_we_i,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic [DW-1:0] flags_nxt_o,
  output logic [DW-1:0] flags_o
);
  alu_op_e       op;
  logic          is_arith, is_sub, use_cin, cin_eff;
  logic [DW-1:0] as_sum, lg_res;
  logic          as_cy, as_hc, cy, ac;

  always_comb begin
    op       = alu_op_e'(op_i);
    is_arith = !op_i[2] || (op == OP_CMP);
    is_sub   = op_i[1] && is_arith;
    use_cin  = (op == OP_ADC) || (op == OP_SBB);
    cin_eff  = carry_i && use_cin;
  end

  alu8_addsub #(.W(DW), .H(NW)) u_addsub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .sub_i  (is_sub),
    .cin_i  (cin_eff),
    .sum_o  (as_sum),
    .cy_o   (as_cy),
    .hc_o   (as_hc)
  );

  alu8_logic #(.W(DW)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0]),
    .res_o (lg_res)
  );

  always_comb begin
    result_o = is_arith ? as_sum : lg_res;
    cy       = is_arith ? as_cy : 1'b0;
    ac       = is_arith ? as_hc : (op == OP_AND);
    acc_we_o = (op != OP_CMP);
  end

  alu8_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_i),
    .res_i  (result_o),
    .cy_i   (cy),
    .ac_i   (ac),
    .nxt_o  (flags_nxt_o),
    .q_o    (flags_o)
  );

  p_logic_cy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[2] && (op_i != 3'd7) |-> !flags_nxt_o[FB_CY]);
  p_add_no_cin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |-> (result_o == acc_i + opnd_i));
  p_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_nxt_o[FB_S] == result_o[DW-1]);
  p_and_ac_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |-> flags_nxt_o[FB_AC]);
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       carry_i = 1'b0;
  logic       flag_we_i = 1'b0;
  logic [7:0] result_o, flags_nxt_o, flags_o;
  logic       acc_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  alu8_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .acc_we_o(acc_we_o), .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
  );

  // {op, a, b, cin, result, flags}
  localparam logic [35:0] VEC [11] = '{
    {3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h92},  // R1 R5 R7
    {3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h57},  // R1 R8 R6
    {3'd1, 8'h0F, 8'h00, 1'b1, 8'h10, 8'h12},  // R1 R7
    {3'd2, 8'h00, 8'h01, 1'b0, 8'hFF, 8'h87},  // R2
    {3'd3, 8'h05, 8'h05, 1'b1, 8'hFF, 8'h87},  // R2 R7
    {3'd7, 8'h40, 8'h40, 1'b0, 8'h00, 8'h56},  // R4 R5
    {3'd4, 8'hF0, 8'h3C, 1'b0, 8'h30, 8'h16},  // R3 R7
    {3'd6, 8'h00, 8'h00, 1'b0, 8'h00, 8'h46},  // R3 R6
    {3'd5, 8'hAA, 8'h55, 1'b0, 8'hFF, 8'h86},  // R3 R9
    {3'd0, 8'h01, 8'h01, 1'b1, 8'h02, 8'h02},  // R10
    {3'd7, 8'h10, 8'h20, 1'b1, 8'hF0, 8'h97}   // R10 R4
  };

  function automatic logic [16:0] ref_model(int op, int a, int b, int c);
    int r, cy, ac, bin;
    logic [7:0] r8, f;
    cy = 0; ac = 0;
    case (op)
      0, 1: begin
        bin = (op == 1) ? c : 0;
        r = a + b + bin; cy = (r > 255);
        ac = (((a % 16) + (b % 16) + bin) > 15);
      end
      2, 3, 7: begin
        bin = (op == 3) ? c : 0;
        r = a - b - bin; cy = (r < 0);
        ac = ((a % 16) >= (b % 16) + bin);
      end
      4: begin r = a & b; ac = 1; end
      5: r = a ^ b;
      default: r = a | b;
    endcase
    r8 = 8'(r);
    f = 8'h02;
    f[7] = r8[7];
    f[6] = (r8 == 8'h00);
    f[4] = 1'(ac);
    f[2] = ($countones(r8) % 2 == 0);
    f[0] = 1'(cy);
    return {(op != 7), r8, f};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(int op, int a, int b, int c);
    op_i = 3'(op); acc_i = 8'(a); opnd_i = 8'(b); carry_i = 1'(c);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #25;
    chk("R11 reset value", 32'(flags_o), 32'h02);
    @(negedge clk_i); rst_ni = 1'b1;

    // directed vector table
    foreach (VEC[i]) begin
      drive(int'(VEC[i][35:33]), int'(VEC[i][32:25]), int'(VEC[i][24:17]), int'(VEC[i][16]));
      #1;
      chk($sformatf("R1 R2 R3 table row %0d result", i), 32'(result_o), 32'(VEC[i][15:8]));
      chk($sformatf("R5 R6 R7 R8 R9 table row %0d flags", i), 32'(flags_nxt_o), 32'(VEC[i][7:0]));
      chk($sformatf("R4 table row %0d write strobe", i), 32'(acc_we_o), 32'(VEC[i][35:33] != 3'd7));
    end

    // exhaustive sweep against the model, both carry-in values
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          int c;
          logic [16:0] e;
          c = (a ^ b ^ op) & 1;
          drive(op, a, b, c);
          #1;
          e = ref_model(op, a, b, c);
          if ({acc_we_o, result_o, flags_nxt_o} !== e)
            chk($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 sweep op %0d a %h b %h c %0d", op, a, b, c),
                32'({acc_we_o, result_o, flags_nxt_o}), 32'(e));
          else n_chk++;
        end

    // flag register load, hold, carry loop-back
    @(negedge clk_i);
    drive(0, 8'hFF, 8'h01, 0); flag_we_i = 1'b1;
    @(negedge clk_i);
    chk("R11 load", 32'(flags_o), 32'h57);
    drive(6, 8'h00, 8'h00, 0); flag_we_i = 1'b0;
    @(negedge clk_i);
    chk("R11 hold with write enable low", 32'(flags_o), 32'h57);
    drive(1, 8'h00, 8'h00, int'(flags_o[0])); flag_we_i = 1'b1;
    #1;
    chk("R1 add-with-carry uses stored carry", 32'(result_o), 32'h01);
    @(negedge clk_i);
    chk("R11 same-cycle update from chained carry", 32'(flags_o), 32'h02);
    flag_we_i = 1'b0;

    rst_ni = 1'b0; #1;
    chk("R11 asynchronous reset", 32'(flags_o), 32'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule